// File: doc/BRIEF.md
# Per-Lane Write Calibration Sweep Controller

This controller searches for a working write calibration offset on every data lane of a memory interface. After a start request it works through the active lanes in ascending order. For each lane it presents an offset and a write latency to an external lane tester and launches one write-then-read-back attempt. It then waits for the tester to answer with done and a pass flag. A failed attempt moves the same lane to the next offset. A passing attempt freezes that lane's offset and moves on to the next lane.

When a lane exhausts its offset range, the controller raises the write latency by one step. It then clears every stored offset and pass flag and begins again at lane 0. When the highest latency also fails, the run ends with a failure code. The stored offsets, the per-lane pass flags, the final latency and a one-byte result code stay on the outputs after the run, so the surrounding logic can read them at any time.

Top module: `wcal_sweep`

## Requirements
- R1: After reset the block is idle: busy, done and testStart are 0, resultCode is 0x00, every lane offset is 0, laneOkMask is 0 and wrLatency is 0.
- R2: A calStart pulse while idle clears all offsets, the pass mask and the result code to 0x00 and sets wrLatency to 0. busy is 1 from the next cycle. A calStart pulse while busy has no effect on the run or its results.
- R3: Each attempt is a one-cycle testStart pulse carrying testLane, testOffset and wrLatency. No new attempt starts until testDone has been seen for the previous one, and lanes are visited in ascending order starting at lane 0.
- R4: A failing answer with the current offset below 15 retries the same lane with the offset plus one. A passing answer keeps that lane's offset, sets its pass bit and starts the next lane at offset 0.
- R5: A failing answer at offset 15 with wrLatency below 3 raises wrLatency by one, clears every offset and pass bit, and restarts at lane 0 with offset 0.
- R6: A passing answer on the last active lane ends the run with resultCode 0xFF. A failing answer at offset 15 with wrLatency 3 ends the run with resultCode 0xFE. wrLatency, the offsets and the mask keep their values at the time the run ends.
- R7: The number of active lanes is laneCount, sampled at start and clamped to 1..5: 0 acts as 1 and values above 5 act as 5. Lanes at or above that count are never tested and report offset 0 and pass bit 0.
- R8: busy stays 1 until the cycle in which done is high. done is high for exactly one cycle with busy 0, and resultCode is valid in that cycle and held until the next accepted start.
- R9: laneOkMask bit i belongs to lane i. laneOffsets bits [4i+3:4i] hold the 4-bit offset of lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| calStart | input | 1 | Start request, accepted only while idle |
| laneCount | input | 3 | Number of active lanes, sampled at start |
| testStart | output | 1 | One-cycle launch of a lane test |
| testLane | output | 3 | Lane under test |
| testOffset | output | 4 | Offset applied to the lane under test |
| wrLatency | output | 2 | Current (and finally chosen) write latency |
| testDone | input | 1 | Tester answer strobe |
| testPass | input | 1 | Tester verdict, valid with testDone |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| resultCode | output | 8 | 0x00 none, 0xFF passed, 0xFE failed |
| laneOffsets | output | 20 | Offsets of all lanes, 4 bits each |
| laneOkMask | output | 5 | Per-lane pass flags |

## Verification
A wrong lane index or offset inside the block is visible at the very next testStart pulse, since testLane and testOffset show it directly. The bench's tester model then answers for the wrong point, so the attempt count also drifts from the expected one. A latency step that fails to clear the stored offsets shows up as a nonzero testOffset on the first launch after the step, one cycle after the failing answer. A wrong end decision shows up in the done cycle as a wrong resultCode, wrLatency, offset vector or mask, all compared against a model built from the tester's per-lane thresholds.

// File: rtl/wcal_pkg.sv
package wcal_pkg;

  localparam logic [7:0] CODE_NONE = 8'h00;
  localparam logic [7:0] CODE_PASS = 8'hFF;
  localparam logic [7:0] CODE_FAIL = 8'hFE;

  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic clearAll;     // new run: wipe offsets, mask, result, latency
    logic incOffset;    // same lane, next offset
    logic recordPass;   // mark current lane as passing
    logic nextLane;     // advance to the next lane
    logic bumpLatency;  // step latency, wipe offsets and mask, lane 0
    logic finishPass;   // latch pass code
    logic finishFail;   // latch fail code
  } wcalStrobes_t;

endpackage

// File: rtl/wcal_ctrl.sv
module wcal_ctrl
  import wcal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         calStart,
  input  logic         testDone,
  input  logic         testPass,
  input  logic         lastLane,
  input  logic         offsetAtMax,
  input  logic         latencyAtMax,
  output wcalStrobes_t strobes,
  output logic         testStart,
  output logic         busy,
  output logic         done
);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } state_t;

  state_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (calStart) begin
          strobes.clearAll = 1'b1;
          nextState        = ST_LAUNCH;
        end
      end
      ST_LAUNCH: nextState = ST_WAIT;
      ST_WAIT: begin
        if (testDone) begin
          if (testPass) begin
            strobes.recordPass = 1'b1;
            if (lastLane) begin
              strobes.finishPass = 1'b1;
              nextState          = ST_FINISH;
            end else begin
              strobes.nextLane = 1'b1;
              nextState        = ST_LAUNCH;
            end
          end else if (!offsetAtMax) begin
            strobes.incOffset = 1'b1;
            nextState         = ST_LAUNCH;
          end else if (!latencyAtMax) begin
            strobes.bumpLatency = 1'b1;
            nextState           = ST_LAUNCH;
          end else begin
            strobes.finishFail = 1'b1;
            nextState          = ST_FINISH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign testStart = (state == ST_LAUNCH);
  assign busy      = (state == ST_LAUNCH) || (state == ST_WAIT);
  assign done      = (state == ST_FINISH);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);

  // R3
  launch_needs_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testStart && !$past(strobes.clearAll)) |-> $past(testDone));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> busy);

endmodule

// File: rtl/wcal_datapath.sv
module wcal_datapath
  import wcal_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int OFFSET_W  = 4,
  parameter int LAT_MIN   = 0,
  parameter int LAT_MAX   = 3,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int COUNT_W  = $clog2(NUM_LANES + 1),
  localparam int LAT_W    = (LAT_MAX > 0) ? $clog2(LAT_MAX + 1) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wcalStrobes_t                  strobes,
  input  logic [COUNT_W-1:0]            laneCount,
  output logic [LANE_W-1:0]             curLane,
  output logic [OFFSET_W-1:0]           curOffset,
  output logic [LAT_W-1:0]              latency,
  output logic                          lastLane,
  output logic                          offsetAtMax,
  output logic                          latencyAtMax,
  output logic [NUM_LANES*OFFSET_W-1:0] laneOffsets,
  output logic [NUM_LANES-1:0]          laneOkMask,
  output logic [7:0]                    resultCode
);

  logic [OFFSET_W-1:0] offReg [NUM_LANES];
  logic [NUM_LANES-1:0] okReg;
  logic [LANE_W-1:0]   lastIdx;
  logic [LANE_W-1:0]   lastSel;

  // clamp the requested lane count into 1..NUM_LANES
  always_comb begin
    if (laneCount == '0)
      lastSel = '0;
    else if (laneCount > COUNT_W'(NUM_LANES))
      lastSel = LANE_W'(NUM_LANES - 1);
    else
      lastSel = LANE_W'(laneCount - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdx    <= '0;
      curLane    <= '0;
      latency    <= LAT_W'(LAT_MIN);
      resultCode <= CODE_NONE;
    end else begin
      if (strobes.clearAll) begin
        lastIdx    <= lastSel;
        curLane    <= '0;
        latency    <= LAT_W'(LAT_MIN);
        resultCode <= CODE_NONE;
      end else begin
        if (strobes.bumpLatency) begin
          curLane <= '0;
          latency <= latency + 1'b1;
        end else if (strobes.nextLane) begin
          curLane <= curLane + 1'b1;
        end
        if (strobes.finishPass)      resultCode <= CODE_PASS;
        else if (strobes.finishFail) resultCode <= CODE_FAIL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LANES; i++) offReg[i] <= '0;
      okReg <= '0;
    end else if (strobes.clearAll || strobes.bumpLatency) begin
      for (int i = 0; i < NUM_LANES; i++) offReg[i] <= '0;
      okReg <= '0;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (curLane == LANE_W'(i)) begin
          if (strobes.incOffset)  offReg[i] <= offReg[i] + 1'b1;
          if (strobes.recordPass) okReg[i]  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    curOffset = offReg[0];
    for (int k = 1; k < NUM_LANES; k++)
      if (curLane == LANE_W'(k)) curOffset = offReg[k];
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pack
    assign laneOffsets[g*OFFSET_W +: OFFSET_W] = offReg[g];
  end

  assign laneOkMask   = okReg;
  assign lastLane     = (curLane == lastIdx);
  assign offsetAtMax  = &curOffset;
  assign latencyAtMax = (latency == LAT_W'(LAT_MAX));

  // R4
  inc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incOffset |-> !offsetAtMax);

  // R7
  lane_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curLane <= lastIdx);

  // R5
  bump_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bumpLatency |=> (okReg == '0) && (curLane == '0) && (curOffset == '0));

  // R4
  pass_moves_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nextLane |=> (curOffset == '0) && okReg[curLane - 1'b1]);

endmodule

// File: rtl/wcal_sweep.sv
module wcal_sweep
  import wcal_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int OFFSET_W  = 4,
  parameter int LAT_MIN   = 0,
  parameter int LAT_MAX   = 3,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int COUNT_W  = $clog2(NUM_LANES + 1),
  localparam int LAT_W    = (LAT_MAX > 0) ? $clog2(LAT_MAX + 1) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          calStart,
  input  logic [COUNT_W-1:0]            laneCount,
  output logic                          testStart,
  output logic [LANE_W-1:0]             testLane,
  output logic [OFFSET_W-1:0]           testOffset,
  output logic [LAT_W-1:0]              wrLatency,
  input  logic                          testDone,
  input  logic                          testPass,
  output logic                          busy,
  output logic                          done,
  output logic [7:0]                    resultCode,
  output logic [NUM_LANES*OFFSET_W-1:0] laneOffsets,
  output logic [NUM_LANES-1:0]          laneOkMask
);

  wcalStrobes_t strobes;
  logic lastLane, offsetAtMax, latencyAtMax;

  wcal_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .calStart     (calStart),
    .testDone     (testDone),
    .testPass     (testPass),
    .lastLane     (lastLane),
    .offsetAtMax  (offsetAtMax),
    .latencyAtMax (latencyAtMax),
    .strobes      (strobes),
    .testStart    (testStart),
    .busy         (busy),
    .done         (done)
  );

  wcal_datapath #(
    .NUM_LANES (NUM_LANES),
    .OFFSET_W  (OFFSET_W),
    .LAT_MIN   (LAT_MIN),
    .LAT_MAX   (LAT_MAX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .laneCount    (laneCount),
    .curLane      (testLane),
    .curOffset    (testOffset),
    .latency      (wrLatency),
    .lastLane     (lastLane),
    .offsetAtMax  (offsetAtMax),
    .latencyAtMax (latencyAtMax),
    .laneOffsets  (laneOffsets),
    .laneOkMask   (laneOkMask),
    .resultCode   (resultCode)
  );

  // R8
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((resultCode == CODE_PASS) || (resultCode == CODE_FAIL)) && !busy);

  // R6
  fail_at_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && resultCode == CODE_FAIL) |-> (wrLatency == LAT_W'(LAT_MAX)));

  // R6
  pass_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && resultCode == CODE_PASS) |-> laneOkMask[0]);

  // R5
  latency_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (wrLatency != $past(wrLatency)))
      |-> (wrLatency == $past(wrLatency) + 1'b1) && (laneOkMask == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done && !$past(done) && !$past(busy)) |-> $stable(resultCode));

endmodule

// File: tb/sim_wcal_sweep.sv
module sim_wcal_sweep;

  typedef struct {
    logic [7:0]  code;
    logic [19:0] offs;
    logic [4:0]  mask;
    logic [1:0]  lat;
    int          attempts;
    int          act;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        calStart = 1'b0;
  logic [2:0]  laneCount = 3'd0;
  logic        testStart;
  logic [2:0]  testLane;
  logic [3:0]  testOffset;
  logic [1:0]  wrLatency;
  logic        testDone = 1'b0;
  logic        testPass = 1'b0;
  logic        busy, done;
  logic [7:0]  resultCode;
  logic [19:0] laneOffsets;
  logic [4:0]  laneOkMask;

  int checks = 0;
  int errors = 0;
  int attempts = 0;
  int rspDelay = 0;
  int activeNow = 5;
  bit badLane = 0;
  bit finished = 0;
  int need [5][4];
  expT expQ [$];

  always #4 clk = ~clk;  // 125 MHz

  wcal_sweep u0 (
    .clk(clk), .rstN(rstN), .calStart(calStart), .laneCount(laneCount),
    .testStart(testStart), .testLane(testLane), .testOffset(testOffset),
    .wrLatency(wrLatency), .testDone(testDone), .testPass(testPass),
    .busy(busy), .done(done), .resultCode(resultCode),
    .laneOffsets(laneOffsets), .laneOkMask(laneOkMask)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setAll(input int v);
    for (int l = 0; l < 5; l++)
      for (int t = 0; t < 4; t++) need[l][t] = v;
  endtask

  // model of the sweep from the tester thresholds (pass when offset >= need)
  task automatic buildExp(input int cnt, output expT e);
    bit ok;
    e.act = (cnt == 0) ? 1 : ((cnt > 5) ? 5 : cnt);
    e.code = 8'hFE; e.attempts = 0; e.offs = '0; e.mask = '0; e.lat = '0;
    for (int t = 0; t < 4; t++) begin
      e.offs = '0; e.mask = '0; e.lat = 2'(t); ok = 1;
      for (int l = 0; l < e.act; l++) begin
        if (need[l][t] <= 15) begin
          e.attempts += need[l][t] + 1;
          e.offs[l*4 +: 4] = 4'(need[l][t]);
          e.mask[l] = 1'b1;
        end else begin
          e.attempts += 16;
          e.offs[l*4 +: 4] = 4'hF;
          ok = 0;
          break;
        end
      end
      if (ok) begin
        e.code = 8'hFF;
        break;
      end
    end
  endtask

  // driver: start a run and push its expected result
  task automatic runCal(input int cnt, input bit poke);
    expT e;
    buildExp(cnt, e);
    @(negedge clk);
    calStart = 1'b1; laneCount = 3'(cnt);
    attempts = 0; badLane = 0; activeNow = e.act;
    expQ.push_back(e);
    @(negedge clk);
    calStart = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", 32'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      calStart = 1'b1; laneCount = 3'd5;   // R2: ignored while busy
      @(negedge clk);
      calStart = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(resultCode === e.code, "R8", "result held after done", 32'(resultCode), 32'(e.code));
    check(busy === 1'b0 && done === 1'b0, "R8", "idle after done", {busy, done}, 0);
  endtask

  // lane tester model
  initial begin
    forever begin
      @(negedge clk);
      while (testStart === 1'b1) begin
        automatic int l = int'(testLane);
        automatic int o = int'(testOffset);
        automatic int t = int'(wrLatency);
        attempts++;
        if (l >= activeNow) badLane = 1;
        repeat (rspDelay + 1) @(negedge clk);
        testDone = 1'b1;
        testPass = (l < 5) ? (need[l][t] <= o) : 1'b0;
        @(negedge clk);
        testDone = 1'b0; testPass = 1'b0;
      end
    end
  end

  // monitor: compare each end-of-run against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected done", 1, 0);
        end else begin
          automatic expT e = expQ.pop_front();
          check(resultCode === e.code, "R6", "result code", 32'(resultCode), 32'(e.code));
          check(laneOffsets === e.offs, "R9", "lane offsets", 32'(laneOffsets), 32'(e.offs));
          check(laneOkMask === e.mask, "R9", "pass mask", 32'(laneOkMask), 32'(e.mask));
          check(wrLatency === e.lat, "R5", "final latency", 32'(wrLatency), 32'(e.lat));
          check(attempts == e.attempts, "R4", "attempt count", 32'(attempts), 32'(e.attempts));
          check(busy === 1'b0, "R8", "busy low with done", 32'(busy), 0);
          check(badLane == 0, "R7", "inactive lane tested", 32'(badLane), 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setAll(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0, "R1", "busy", 32'(busy), 0);
    check(done === 1'b0, "R1", "done", 32'(done), 0);
    check(testStart === 1'b0, "R1", "testStart", 32'(testStart), 0);
    check(resultCode === 8'h00, "R1", "resultCode", 32'(resultCode), 0);
    check(laneOffsets === '0 && laneOkMask === '0 && wrLatency === '0, "R1",
          "offsets/mask/latency", {laneOffsets, laneOkMask, wrLatency}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4: all lanes pass immediately
    rspDelay = 0;
    runCal(5, 0);

    // R4: varied offsets on three lanes
    rspDelay = 2;
    setAll(16);
    need[0][0] = 3; need[1][0] = 0; need[2][0] = 7;
    runCal(3, 0);

    // R5: latency steps, offset 15 boundary passes
    rspDelay = 1;
    setAll(16);
    need[0][0] = 1; need[1][0] = 2;
    need[1][1] = 4;
    need[0][2] = 2; need[1][2] = 4; need[2][2] = 1; need[3][2] = 15;
    runCal(4, 0);

    // R6: everything fails, run ends at the top latency
    rspDelay = 0;
    setAll(16);
    need[0][3] = 5;
    runCal(2, 0);

    // R7: single active lane, others report zero
    setAll(3);
    need[0][0] = 9;
    runCal(1, 0);

    // R7: count 0 acts as 1, count 7 acts as 5
    setAll(2);
    runCal(0, 0);
    runCal(7, 0);

    // R2: start while busy is ignored
    rspDelay = 1;
    setAll(6);
    runCal(2, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule